// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is the control port of a mixed-signal audio front end. A host writes configuration bytes over a two-wire serial bus (I2C) into a bank of sixteen 8-bit control registers. The same port lets the host read back a one-byte status word holding two live indicators: stereo reception and a soft-mute in progress. The slave answers a single fixed 7-bit address. SDA is open-drain, so the block only ever pulls the line low or releases it.

A write transaction has three parts. The address byte comes first. The next byte is a control byte that carries a register index and three mode flags. Any number of data bytes follow it. One flag makes the index advance after each data byte, so consecutive registers can be loaded in one burst. Another flag stops a write to register 0 from raising the offset-calibration ("auto zero") start strobe. The third flag, together with bit 0 of the last register, enables test mode. Each accepted data byte updates its register and pulses that register's own update strobe once its acknowledge clock ends.

SCL and SDA are sampled by a fast system clock, at least 16 times the bit rate, which supports bus rates up to 500 kbit/s. Both lines pass through a two-stage synchronizer and a stability filter before any edge or bus condition is decoded.

Top module: `i2c_rb_slave`

## Requirements
- R1: After reset every register reads 0x00, every strobe output and the test-mode flag are low, and SDA is released (`sda_oe_o` = 0).
- R2: An address byte whose upper seven bits equal 1000110 is acknowledged. Any other address gets no acknowledge, and no register changes until the next start condition.
- R3: In a write (address bit 0 = 0), the byte after the address is the control byte and every later byte is data. Each of these bytes is acknowledged. After each data byte's acknowledge clock, the target register holds the byte, and that register's bit of `wr_stb_o` pulses for exactly one cycle with no other bit set.
- R4: When control bit 4 is 1, the register index advances by one after each data byte, and it wraps from 15 to 0.
- R5: When control bit 4 is 0, every data byte of the transaction goes to the register named by control bits 3..0.
- R6: A data write to register 0 pulses `autozero_o` for one cycle, in the same cycle as its update strobe, if control bit 6 was 0. If control bit 6 was 1, there is no pulse.
- R7: In a read (address bit 0 = 1), the slave sends status bytes with `stereo_i` in bit 3, `softmute_i` in bit 2 and 0 in every other bit. It sends another byte each time the host acknowledges, and it stops and releases SDA after a host non-acknowledge.
- R8: `test_mode_o` is 1 only while control bit 5 of the most recent control byte is 1 and bit 0 of register 15 is 1.
- R9: A stop condition aborts any phase and releases SDA. A repeated start, sent without a stop, begins a new address phase, and a control byte with no data bytes changes no register.
- R10: A pulse on SCL shorter than `FILT_LEN` system clocks is ignored and does not disturb the byte being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 16 times the bus bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line, as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| stereo_i | input | 1 | Stereo-detected indicator for the status byte |
| softmute_i | input | 1 | Soft-mute-active indicator for the status byte |
| regs_o | output | 128 | Register contents, register k at bits 8k+7..8k |
| wr_stb_o | output | 16 | One-cycle update strobe per register |
| autozero_o | output | 1 | One-cycle offset-calibration start strobe |
| test_mode_o | output | 1 | Test-mode enable |

## Verification
The bench targets the corners where a slave most often misbehaves. The index wrap from 15 to 0 is exercised with auto zero enabled; a design that saturates at 15 or drops the wrap would write the wrong register and miss the auto-zero strobe. A design that treated the calibration-suppress flag as ignored would pulse `autozero_o` on a suppressed write to register 0. A design that did not gate on the address match would ACK or write after a mismatched address. Other cases are a repeated start into a read, a one-cycle glitch on SCL in the middle of a byte (an unfiltered design shifts an extra bit), and a host non-acknowledge at the end of a read (a slave that does not release the line would hold SDA low).

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
  localparam int unsigned SUB_AZ_BIT = 6;
  localparam int unsigned SUB_T_BIT  = 5;
  localparam int unsigned SUB_AI_BIT = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } bus_state_e;
endpackage

// File: rtl/i2c_rb_filter.sv
module i2c_rb_filter #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      q_o    <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], d_i};
      if (sync_q[1] != q_o) begin
        if (cnt_q == CW'(FILT_LEN - 1)) begin
          q_o   <= sync_q[1];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/i2c_rb_engine.sv
module i2c_rb_engine
  import i2c_rb_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16,
  parameter logic [6:0]  DEV_ADDR = 7'b1000110,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             sda_i,
  input  logic [7:0]       status_i,
  output logic             sda_oe_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic             wr_az_keep_o,
  output logic             t_flag_o
);
  bus_state_e       st_q;
  logic [3:0]       cnt_q;
  logic [7:0]       sh_q, tx_q, dat_q;
  logic [IDX_W-1:0] idx_q;
  logic             rd_q, ai_q, az_q, nack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;  cnt_q <= '0;  sh_q <= '0;  tx_q <= '0;  dat_q <= '0;
      idx_q <= '0;  rd_q <= 1'b0;  ai_q <= 1'b0;  az_q <= 1'b0;  nack_q <= 1'b0;
      sda_oe_o <= 1'b0;  wr_en_o <= 1'b0;  wr_idx_o <= '0;  wr_data_o <= '0;
      wr_az_keep_o <= 1'b0;  t_flag_o <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (stop_i) begin
        st_q     <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (start_i) begin
        st_q     <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (scl_rise_i && cnt_q < 4'd8) begin
              sh_q  <= {sh_q[6:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              if (st_q == ST_ADDR) begin
                if (sh_q[7:1] == DEV_ADDR) begin
                  sda_oe_o <= 1'b1;
                  rd_q     <= sh_q[0];
                  st_q     <= ST_ADDR_ACK;
                end else begin
                  st_q <= ST_IDLE;  // ignore bus until next start
                end
              end else if (st_q == ST_SUB) begin
                sda_oe_o <= 1'b1;
                az_q     <= sh_q[SUB_AZ_BIT];
                t_flag_o <= sh_q[SUB_T_BIT];
                ai_q     <= sh_q[SUB_AI_BIT];
                idx_q    <= sh_q[IDX_W-1:0];
                st_q     <= ST_SUB_ACK;
              end else begin
                sda_oe_o <= 1'b1;
                dat_q    <= sh_q;
                st_q     <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall_i) begin
            cnt_q <= '0;
            if (rd_q) begin
              tx_q     <= status_i;
              sda_oe_o <= ~status_i[7];
              st_q     <= ST_RDATA;
            end else begin
              sda_oe_o <= 1'b0;
              st_q     <= ST_SUB;
            end
          end
          ST_SUB_ACK: if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            cnt_q    <= '0;
            st_q     <= ST_WDATA;
          end
          ST_WDATA_ACK: if (scl_fall_i) begin
            sda_oe_o     <= 1'b0;
            cnt_q        <= '0;
            wr_en_o      <= 1'b1;
            wr_idx_o     <= idx_q;
            wr_data_o    <= dat_q;
            wr_az_keep_o <= az_q;
            if (ai_q) idx_q <= idx_q + 1'b1;  // wraps at NUM_REGS
            st_q         <= ST_WDATA;
          end
          ST_RDATA: if (scl_fall_i) begin
            if (cnt_q == 4'd7) begin
              sda_oe_o <= 1'b0;
              cnt_q    <= '0;
              st_q     <= ST_RACK;
            end else begin
              tx_q     <= {tx_q[6:0], 1'b0};
              sda_oe_o <= ~tx_q[6];
              cnt_q    <= cnt_q + 1'b1;
            end
          end
          ST_RACK: begin
            if (scl_rise_i) nack_q <= sda_i;
            if (scl_fall_i) begin
              if (nack_q) begin
                st_q <= ST_IDLE;
              end else begin
                tx_q     <= status_i;
                sda_oe_o <= ~status_i[7];
                cnt_q    <= '0;
                st_q     <= ST_RDATA;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_rb_regfile.sv
module i2c_rb_regfile #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned DATA_W   = 8,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned TEST_IDX = NUM_REGS - 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic                       wr_az_keep_i,
  input  logic                       t_flag_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic [NUM_REGS-1:0]        wr_stb_o,
  output logic                       autozero_o,
  output logic                       test_mode_o
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic              hit;
    assign hit = wr_en_i && (wr_idx_i == IDX_W'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q           <= '0;
        wr_stb_o[k] <= 1'b0;
      end else begin
        wr_stb_o[k] <= hit;
        if (hit) q <= wr_data_i;
      end
    end
    assign regs_o[k*DATA_W +: DATA_W] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) autozero_o <= 1'b0;
    else         autozero_o <= wr_en_i && (wr_idx_i == '0) && !wr_az_keep_i;
  end

  assign test_mode_o = t_flag_i & regs_o[TEST_IDX*DATA_W];
endmodule

// File: rtl/i2c_rb_slave.sv
module i2c_rb_slave #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned FILT_LEN = 3,
  parameter logic [6:0]  DEV_ADDR = 7'b1000110,
  localparam int unsigned DATA_W  = 8,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe_o,
  input  logic                       stereo_i,
  input  logic                       softmute_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic [NUM_REGS-1:0]        wr_stb_o,
  output logic                       autozero_o,
  output logic                       test_mode_o
);
  logic scl_f, sda_f, scl_d, sda_d;
  logic scl_rise, scl_fall, start_c, stop_c;
  logic wr_en, wr_az_keep, t_flag;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic [7:0]        status;

  i2c_rb_filter #(.FILT_LEN(FILT_LEN)) i_filt_scl (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i), .q_o(scl_f));
  i2c_rb_filter #(.FILT_LEN(FILT_LEN)) i_filt_sda (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_f));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_d;
  assign scl_fall = ~scl_f & scl_d;
  // bus conditions only while SCL is steadily high
  assign start_c  = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_c   = scl_f & scl_d & ~sda_d & sda_f;
  assign status   = {4'b0000, stereo_i, softmute_i, 2'b00};

  i2c_rb_engine #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) i_engine (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .scl_rise_i   (scl_rise),
    .scl_fall_i   (scl_fall),
    .start_i      (start_c),
    .stop_i       (stop_c),
    .sda_i        (sda_f),
    .status_i     (status),
    .sda_oe_o     (sda_oe_o),
    .wr_en_o      (wr_en),
    .wr_idx_o     (wr_idx),
    .wr_data_o    (wr_data),
    .wr_az_keep_o (wr_az_keep),
    .t_flag_o     (t_flag)
  );

  i2c_rb_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) i_regfile (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en),
    .wr_idx_i     (wr_idx),
    .wr_data_i    (wr_data),
    .wr_az_keep_i (wr_az_keep),
    .t_flag_i     (t_flag),
    .regs_o       (regs_o),
    .wr_stb_o     (wr_stb_o),
    .autozero_o   (autozero_o),
    .test_mode_o  (test_mode_o)
  );
endmodule

// File: rtl/i2c_rb_checker.sv
module i2c_rb_checker #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned DATA_W   = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NUM_REGS*DATA_W-1:0] regs_o,
  input logic [NUM_REGS-1:0]        wr_stb_o,
  input logic                       autozero_o,
  input logic                       test_mode_o
);
  p_stb_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_stb_o));

  p_regs_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_o == '0) |-> $stable(regs_o));

  p_az_with_reg0_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    autozero_o |-> wr_stb_o[0]);

  p_az_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    autozero_o |=> !autozero_o);

  p_test_needs_reg15_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_mode_o |-> regs_o[(NUM_REGS-1)*DATA_W]);
endmodule

bind i2c_rb_slave i2c_rb_checker #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) i_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .regs_o(regs_o), .wr_stb_o(wr_stb_o),
  .autozero_o(autozero_o), .test_mode_o(test_mode_o));

// File: tb/test_i2c_rb_slave.sv
module test_i2c_rb_slave;
  localparam int Q = 25;  // quarter bit in clocks: 500 kbit/s at 50 MHz

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_drv = 1'b1;
  logic stereo = 1'b0, softmute = 1'b0;
  logic         sda_oe;
  logic [127:0] regs;
  logic [15:0]  wr_stb;
  logic         autozero, test_mode;
  wire          sda_line = sda_drv & ~sda_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [12:0] exp_q[$];  // {az, idx[3:0], data[7:0]}
  logic [12:0] mon_e;
  logic [7:0]  model[16];
  bit          t_last = 1'b0;

  always #10 clk = ~clk;

  i2c_rb_slave i_i2c_rb_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .stereo_i(stereo), .softmute_i(softmute), .regs_o(regs), .wr_stb_o(wr_stb),
    .autozero_o(autozero), .test_mode_o(test_mode));

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start; sda_drv = 1; wq(Q); scl = 1; wq(Q); sda_drv = 0; wq(Q); scl = 0; wq(Q); endtask
  task automatic bus_stop;  sda_drv = 0; wq(Q); scl = 1; wq(Q); sda_drv = 1; wq(Q); endtask

  task automatic wbit(input logic b, input bit glitch);
    sda_drv = b; wq(Q); scl = 1; wq(Q);
    if (glitch) begin scl = 0; wq(1); scl = 1; wq(Q - 1); end
    else wq(Q);
    scl = 0; wq(Q);
  endtask

  task automatic rbit(output logic b);
    sda_drv = 1; wq(Q); scl = 1; wq(Q); b = sda_line; wq(Q); scl = 0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    logic x;
    for (int i = 7; i >= 0; i--) wbit(b[i], glitch);
    rbit(x);
    ack = !x;
  endtask

  task automatic recv_byte(input bit host_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) rbit(b[i]);
    wbit(!host_ack, 1'b0);
  endtask

  // full write: address, control byte, n data bytes, stop
  task automatic wr_txn(input logic [7:0] sub, input logic [7:0] d0, input logic [7:0] d1,
                        input logic [7:0] d2, input int n, input bit glitch);
    bit ack;
    logic [3:0] idx;
    logic [7:0] d[3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    idx = sub[3:0];
    bus_start;
    send_byte(8'h8C, glitch, ack);
    chk(ack, "R2 address 1000110 acknowledged", 32'(ack), 1);
    send_byte(sub, glitch, ack);
    chk(ack, "R3 control byte acknowledged", 32'(ack), 1);
    t_last = sub[5];
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({(idx == 4'd0) && !sub[6], idx, d[i]});
      model[idx] = d[i];
      send_byte(d[i], glitch, ack);
      chk(ack, "R3 data byte acknowledged", 32'(ack), 1);
      if (sub[4]) idx = idx + 4'd1;
    end
    bus_stop;
    wq(10);
    chk(exp_q.size() == 0, "R3 all expected writes seen", 32'(exp_q.size()), 0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && autozero && !wr_stb[0]) chk(0, "R6 autozero without reg0 write", 32'(wr_stb), 1);
    if (rst_n && |wr_stb) begin
      if (exp_q.size() == 0) begin
        chk(0, "R2/R9 unexpected register write", 32'(wr_stb), 0);
      end else begin
        mon_e = exp_q.pop_front();
        chk(wr_stb == (16'h1 << mon_e[11:8]), "R3/R4/R5 update strobe index",
            32'(wr_stb), 32'(16'h1 << mon_e[11:8]));
        chk(regs[mon_e[11:8]*8 +: 8] == mon_e[7:0], "R3 register value after ack",
            32'(regs[mon_e[11:8]*8 +: 8]), 32'(mon_e[7:0]));
        chk(autozero == mon_e[12], "R6 autozero strobe", 32'(autozero), 32'(mon_e[12]));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary;
    end
  end

  initial begin
    bit ack;
    logic [7:0] rb;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    wq(5);
    rst_n = 1'b1;
    wq(5);
    // R1 reset state
    chk(regs == '0, "R1 registers cleared", regs[31:0], 0);
    chk(wr_stb == 0 && autozero == 0, "R1 strobes low", 32'({wr_stb, autozero}), 0);
    chk(test_mode == 0, "R1 test mode low", 32'(test_mode), 0);
    chk(sda_oe == 0, "R1 SDA released", 32'(sda_oe), 0);

    // R2 wrong address: no ack, nothing written
    bus_start;
    send_byte(8'h8E, 1'b0, ack);
    chk(!ack, "R2 mismatched address not acknowledged", 32'(ack), 0);
    send_byte(8'h03, 1'b0, ack);
    send_byte(8'hFF, 1'b0, ack);
    chk(!ack, "R2 ignored bus gives no ack", 32'(ack), 0);
    bus_stop;
    wq(10);
    chk(regs[3*8 +: 8] == 8'h00, "R2 register unchanged after mismatch", 32'(regs[3*8 +: 8]), 0);

    // R3 single write
    wr_txn(8'h03, 8'hA5, 8'h00, 8'h00, 1, 1'b0);
    // R5 fixed index burst
    wr_txn(8'h05, 8'h11, 8'h22, 8'h33, 3, 1'b0);
    chk(regs[5*8 +: 8] == 8'h33, "R5 last byte kept in fixed register", 32'(regs[5*8 +: 8]), 32'h33);
    chk(regs[6*8 +: 8] == 8'h00, "R5 neighbour untouched", 32'(regs[6*8 +: 8]), 0);
    // R4 autoincrement with wrap 14,15,0 and R6 autozero
    wr_txn(8'h1E, 8'h5C, 8'h40, 8'h9D, 3, 1'b0);
    chk(regs[0 +: 8] == 8'h9D, "R4 wrap reached register 0", 32'(regs[0 +: 8]), 32'h9D);
    // R6 suppressed autozero
    wr_txn(8'h40, 8'h77, 8'h00, 8'h00, 1, 1'b0);
    // R8 test mode
    wr_txn(8'h3F, 8'h01, 8'h00, 8'h00, 1, 1'b0);
    chk(test_mode == 1'b1, "R8 test mode on with T and reg15 bit0", 32'(test_mode), 1);
    wr_txn(8'h0F, 8'h01, 8'h00, 8'h00, 1, 1'b0);
    chk(test_mode == 1'b0, "R8 test mode off when T clear", 32'(test_mode), 0);
    wr_txn(8'h2F, 8'h00, 8'h00, 8'h00, 1, 1'b0);
    chk(test_mode == 1'b0, "R8 test mode off when reg15 bit0 clear", 32'(test_mode), 0);

    // R7 read, two bytes
    stereo = 1; softmute = 1;
    bus_start;
    send_byte(8'h8D, 1'b0, ack);
    chk(ack, "R7 read address acknowledged", 32'(ack), 1);
    recv_byte(1'b1, rb);
    chk(rb == 8'h0C, "R7 status byte 1", 32'(rb), 32'h0C);
    recv_byte(1'b0, rb);
    chk(rb == 8'h0C, "R7 status byte 2", 32'(rb), 32'h0C);
    chk(sda_oe == 0, "R7 SDA released after host nack", 32'(sda_oe), 0);
    bus_stop;

    // R9 repeated start into read, control byte without data
    stereo = 0; softmute = 1;
    bus_start;
    send_byte(8'h8C, 1'b0, ack);
    send_byte(8'h09, 1'b0, ack);
    chk(ack, "R9 control byte acknowledged", 32'(ack), 1);
    bus_start;
    send_byte(8'h8D, 1'b0, ack);
    chk(ack, "R9 repeated start address acknowledged", 32'(ack), 1);
    recv_byte(1'b0, rb);
    chk(rb == 8'h04, "R9 R7 status after repeated start", 32'(rb), 32'h04);
    bus_stop;
    wq(10);
    chk(regs[9*8 +: 8] == 8'h00, "R9 no write without data byte", 32'(regs[9*8 +: 8]), 0);
    chk(sda_oe == 0, "R9 SDA released after stop", 32'(sda_oe), 0);

    // R10 SCL glitch during every bit
    wr_txn(8'h07, 8'h5A, 8'h00, 8'h00, 1, 1'b1);
    chk(regs[7*8 +: 8] == 8'h5A, "R10 byte intact despite SCL glitch", 32'(regs[7*8 +: 8]), 32'h5A);

    // final register image
    for (int i = 0; i < 16; i++)
      chk(regs[i*8 +: 8] == model[i], "R3 final register image", 32'(regs[i*8 +: 8]), 32'(model[i]));
    chk(test_mode == (t_last & model[15][0]), "R8 final test mode", 32'(test_mode), 32'(t_last & model[15][0]));

    done = 1'b1;
    summary;
  end
endmodule